// File: doc/BRIEF.md
# Vector length configuration unit

This block serves one vector configuration request per cycle. A request carries the application vector length (AVL), an element width code, a register-grouping multiplier code and two flags telling whether the destination and source register indices are zero. From the element width and the multiplier it derives the maximum vector length VLMAX. It grants a vector length, returns it on the writeback port in the same cycle, and loads the vector length and vector type state registers at the next clock edge.

The multiplier may be integral (1, 2, 4, 8) or fractional (1/2, 1/4, 1/8). A fractional multiplier shrinks VLMAX as though the register length were divided by its denominator. The stored type still reads as multiplier 1, so the fractional form adds no state. A combination whose VLMAX comes out as zero, or the reserved multiplier code, is illegal and raises the illegal-type flag.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, the vector length output is 0 and the type output has only the illegal flag set (bit XLEN-1 = 1, all other bits 0).
- R2: Element width codes are 00=8, 01=16, 10=32, 11=64 bits. Integral multiplier codes are 000=1, 001=2, 010=4, 011=8, and give VLMAX = VLEN*LMUL/SEW. With a nonzero source index the granted length is min(AVL, VLMAX).
- R3: Fractional multiplier codes are 111=1/2, 110=1/4, 101=1/8, and give VLMAX = (VLEN/denominator)/SEW.
- R4: After a legal fractional request the type output records multiplier code 000 in bits [2:0]. Bits [4:3] always hold the element width code of a legal request, and bit XLEN-1 is 0.
- R5: A request with a nonzero destination and a zero source sets the length to VLMAX.
- R6: A legal request with both indices zero leaves the length unchanged and writes the new type. Its writeback value is the current length.
- R7: When multiplier code 100 is requested, or VLMAX computes to 0, the type becomes the illegal flag alone, the length becomes 0 and the writeback value is 0.
- R8: The writeback value appears combinationally in the cycle the request is valid. The length and type outputs change at the following clock edge.
- R9: In a cycle with no valid request the length and type outputs hold, and the writeback value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_rd_zero | input | 1 | Destination register index is zero |
| req_rs1_zero | input | 1 | Source register index is zero |
| req_avl | input | XLEN | Requested application vector length |
| req_sew | input | 2 | Element width code |
| req_lmul | input | 3 | Multiplier code |
| wb_data | output | XLEN | Granted length for writeback |
| vl_o | output | VLW | Current vector length state |
| vtype_o | output | XLEN | Current vector type state |

## Verification
The hardest case to reach is the keep-length form arriving after a configuration change. Here the held length can exceed the new VLMAX, or the new type can be illegal and force the length to zero. The stimulus therefore sets a large length with 64-bit elements at multiplier 8, then issues keep requests with fractional and illegal types. A long pseudo-random run follows, which mixes all flag combinations and idle cycles, and a behavioural model checks every cycle against it.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    localparam int SEW_W  = 2;
    localparam int LMUL_W = 3;
    localparam int VT_LMUL_LSB = 0;
    localparam int VT_SEW_LSB  = 3;
    localparam logic [LMUL_W-1:0] LMUL_RESERVED = 3'b100;
    localparam logic [LMUL_W-1:0] LMUL_ONE      = 3'b000;
endpackage

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int VLW = $clog2(VLEN) + 1
) (
    input  logic [SEW_W-1:0]  sew,
    input  logic [LMUL_W-1:0] lmul,
    output logic [VLW-1:0]    vlmax,
    output logic              frac,
    output logic              illegal
);
    localparam logic [VLW-1:0] VLEN_V = VLW'(VLEN);

    logic [3:0] shift;

    always_comb begin
        frac = lmul[2] && (lmul != LMUL_RESERVED);
        if (!lmul[2]) begin
            shift = 4'd3 + {2'b00, sew} - {2'b00, lmul[1:0]};
        end else begin
            shift = 4'd3 + {2'b00, sew} + (4'd4 - {2'b00, lmul[1:0]});
        end
        vlmax   = VLEN_V >> shift;
        illegal = (lmul == LMUL_RESERVED) || (vlmax == '0);
    end
endmodule

// File: rtl/vcfg_grant.sv
module vcfg_grant #(
    parameter int XLEN = 32,
    parameter int VLW  = 8
) (
    input  logic [XLEN-1:0] avl,
    input  logic [VLW-1:0]  vlmax,
    input  logic [VLW-1:0]  cur_vl,
    input  logic            rd_zero,
    input  logic            rs1_zero,
    input  logic            illegal,
    output logic [VLW-1:0]  new_vl
);
    logic [XLEN-1:0] vlmax_x;

    always_comb begin
        vlmax_x = {{(XLEN-VLW){1'b0}}, vlmax};
        if (illegal) begin
            new_vl = '0;
        end else if (!rs1_zero) begin
            new_vl = (avl < vlmax_x) ? avl[VLW-1:0] : vlmax;
        end else if (!rd_zero) begin
            new_vl = vlmax;
        end else begin
            new_vl = cur_vl;
        end
    end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int XLEN = 32,
    localparam int VLW = $clog2(VLEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_rd_zero,
    input  logic              req_rs1_zero,
    input  logic [XLEN-1:0]   req_avl,
    input  logic [SEW_W-1:0]  req_sew,
    input  logic [LMUL_W-1:0] req_lmul,
    output logic [XLEN-1:0]   wb_data,
    output logic [VLW-1:0]    vl_o,
    output logic [XLEN-1:0]   vtype_o
);
    typedef struct packed {
        logic [VLW-1:0]  vl;
        logic [XLEN-1:0] vtype;
    } cfg_state_t;

    localparam logic [XLEN-1:0] VILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

    cfg_state_t st_d, st_q;
    logic [VLW-1:0] vlmax;
    logic           frac, illegal;
    logic [VLW-1:0] new_vl;

    vcfg_vlmax #(.VLEN(VLEN)) u_vlmax (
        .sew(req_sew), .lmul(req_lmul),
        .vlmax(vlmax), .frac(frac), .illegal(illegal)
    );

    vcfg_grant #(.XLEN(XLEN), .VLW(VLW)) u_grant (
        .avl(req_avl), .vlmax(vlmax), .cur_vl(st_q.vl),
        .rd_zero(req_rd_zero), .rs1_zero(req_rs1_zero),
        .illegal(illegal), .new_vl(new_vl)
    );

    always_comb begin
        st_d    = st_q;
        wb_data = '0;
        if (req_valid) begin
            st_d.vl = new_vl;
            wb_data = {{(XLEN-VLW){1'b0}}, new_vl};
            if (illegal) begin
                st_d.vtype = VILL_ONLY;
            end else begin
                st_d.vtype = '0;
                st_d.vtype[VT_SEW_LSB +: SEW_W]   = req_sew;
                st_d.vtype[VT_LMUL_LSB +: LMUL_W] = frac ? LMUL_ONE : req_lmul;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vl    <= '0;
            st_q.vtype <= VILL_ONLY;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_o    = st_q.vl;
    assign vtype_o = st_q.vtype;

    assert_grant_le_avl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_rs1_zero) |-> (wb_data <= req_avl));

    assert_frac_lmul_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && frac && !illegal) |=> (vtype_o[2:0] == 3'b000 && !vtype_o[XLEN-1]));

    assert_keep_vl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rd_zero && req_rs1_zero && !illegal) |=> $stable(vl_o));

    assert_vill_zero_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_o[XLEN-1] |-> (vl_o == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(vl_o) && $stable(vtype_o)));
endmodule

// File: tb/vcfg_unit_bench.sv
module vcfg_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 128;
    localparam int XLEN = 32;
    localparam int VLW  = $clog2(VLEN) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_rd_zero = 1'b0, req_rs1_zero = 1'b0;
    logic [XLEN-1:0] req_avl = '0;
    logic [1:0] req_sew = '0;
    logic [2:0] req_lmul = '0;
    logic [XLEN-1:0] wb_data, vtype_o;
    logic [VLW-1:0] vl_o;

    int checks = 0, errors = 0;
    int m_vl = 0;
    longint m_vtype = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcfg_unit #(.VLEN(VLEN), .XLEN(XLEN)) u_vcfg_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_rd_zero(req_rd_zero), .req_rs1_zero(req_rs1_zero),
        .req_avl(req_avl), .req_sew(req_sew), .req_lmul(req_lmul),
        .wb_data(wb_data), .vl_o(vl_o), .vtype_o(vtype_o)
    );

    function automatic int ref_vlmax(int sew, int lmul);
        int base;
        if (lmul == 4) return 0;
        if (lmul < 4) base = VLEN * (1 << lmul);
        else base = VLEN / (1 << (8 - lmul));
        return base / (8 << sew);
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int exp_wb;
    longint exp_vt;

    task automatic model_req(bit rdz, bit rsz, int avl, int sew, int lmul);
        int vmax;
        vmax = ref_vlmax(sew, lmul);
        if (vmax == 0) begin
            exp_wb = 0;
            exp_vt = longint'(1) << (XLEN-1);
        end else begin
            if (!rsz) exp_wb = (avl < vmax) ? avl : vmax;
            else if (!rdz) exp_wb = vmax;
            else exp_wb = m_vl;
            exp_vt = (sew << 3) | ((lmul >= 5) ? 0 : lmul);
        end
    endtask

    task automatic do_req(string tag, bit v, bit rdz, bit rsz, int avl, int sew, int lmul);
        @(negedge clk);
        req_valid = v; req_rd_zero = rdz; req_rs1_zero = rsz;
        req_avl = avl; req_sew = sew[1:0]; req_lmul = lmul[2:0];
        #1;
        if (v) begin
            model_req(rdz, rsz, avl, sew, lmul);
            chk({tag, " wb R8"}, wb_data, exp_wb);
            chk({tag, " vl before edge R8"}, vl_o, m_vl);
            m_vl = exp_wb;
            m_vtype = exp_vt;
        end else begin
            chk({tag, " idle wb R9"}, wb_data, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " vl"}, vl_o, m_vl);
        chk({tag, " vtype"}, vtype_o, m_vtype);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        m_vtype = longint'(1) << (XLEN-1);
        repeat (3) @(negedge clk);
        chk("R1 reset vl", vl_o, 0);
        chk("R1 reset vtype", vtype_o, m_vtype);
        rst_n = 1'b1;
        // R2 integral multipliers
        do_req("R2 e8 m1 avl 5", 1, 0, 0, 5, 0, 0);
        chk("R2 vl=5", vl_o, 5);
        do_req("R2 e8 m8 avl big", 1, 0, 0, 1000, 0, 3);
        chk("R2 vl=128", vl_o, 128);
        do_req("R2 e32 m2 avl 100", 1, 0, 0, 100, 2, 1);
        chk("R2 vl=8", vl_o, 8);
        // R3 fractional
        do_req("R3 e8 f2", 1, 0, 0, 999, 0, 7);
        chk("R3 vl=8", vl_o, 8);
        do_req("R3 e16 f8", 1, 0, 0, 999, 1, 5);
        chk("R3 vl=1", vl_o, 1);
        do_req("R3 e8 f4", 1, 1, 0, 3, 0, 6);
        chk("R3 vl=3", vl_o, 3);
        chk("R4 frac lmul field", vtype_o[2:0], 0);
        chk("R4 sew field", vtype_o[4:3], 0);
        // R5 vlmax
        do_req("R5 e16 m4", 1, 0, 1, 0, 1, 2);
        chk("R5 vl=32", vl_o, 32);
        // R6 keep, new vlmax below held vl
        do_req("R6 setup e64 m8", 1, 0, 1, 0, 3, 3);
        chk("R6 setup vl=16", vl_o, 16);
        do_req("R6 keep e16 f2", 1, 1, 1, 0, 1, 7);
        chk("R6 keep vl", vl_o, 16);
        chk("R6 keep vtype", vtype_o, (1 << 3));
        // R7 illegal
        do_req("R7 keep e64 f4", 1, 1, 1, 0, 3, 6);
        chk("R7 vl=0", vl_o, 0);
        chk("R7 vill", vtype_o, longint'(1) << (XLEN-1));
        do_req("R7 reserved code", 1, 0, 0, 4, 0, 4);
        chk("R7 reserved vl", vl_o, 0);
        do_req("R7 e32 f8", 1, 0, 0, 4, 2, 5);
        // R9 idle
        do_req("R2 restore", 1, 0, 0, 7, 0, 0);
        do_req("R9 idle", 0, 0, 0, 50, 3, 3);
        chk("R9 vl held", vl_o, 7);
        // random mix
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_req("R2 random", lfsr[0] | lfsr[1], lfsr[2], lfsr[3],
                   int'(lfsr[15:8]) + (lfsr[16] ? 200 : 0), int'(lfsr[5:4]), int'(lfsr[20:18]));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule